// File: doc/BRIEF.md
# Broadcast-form FIR filter with truncated tap multipliers

This block is a 30-tap FIR filter in transposed (broadcast) form. Each accepted 16-bit signed sample goes to every tap multiplier in the same cycle. The products are then summed along a chain of registered adders, so the critical path stays one multiplier plus one adder deep whatever the tap count. Samples and coefficients are Q1.15 fractions in [-1, 1). The filter output is rounded and saturated back to Q1.15.

To save area and energy, every tap multiplier is a truncated signed array multiplier. It never builds the lowest partial-product columns of the 32-bit product. In their place it adds a one-bit correction that depends on the data. The coefficients sit in a small register bank that is written through a simple write port. This lets a set of coefficients tuned for the inexact arithmetic replace the exact set without any change to the datapath.

Top module: `trunc_bcast_fir`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `outValid` = 0, `outSample` = 0 and `inReady` = 0, and every coefficient is cleared to zero.
- R2: From the second clock edge after `rst` falls, `inReady` is 1 in every cycle.
- R3: A sample is accepted at an edge where `inValid` and `inReady` are both 1. Its result appears with `outValid` = 1 exactly two edges later. `outValid` is never 1 at any other time, and `outSample` holds its value while `outValid` is 0.
- R4: The output for accepted sample n is the sum over taps k = 0..29 of tap product(h_k, x[n-k]). Only accepted samples count as x; cycles with `inValid` low do not advance the filter. Samples from before reset are zero.
- R5: A tap product of Q1.15 operands a (coefficient) and b (sample) equals a*b minus the sum of a_i&b_j*2^(i+j) over all raw bit pairs with i+j <= 14, plus 2^15 when any bit pair with i+j = 14 is 1. The product is a 32-bit integer scaled by 2^30.
- R6: The accumulated sum S (36-bit, scaled 2^30) is output as floor((S + 2^14) / 2^15), clamped to [-32768, 32767].
- R7: A write with `coefWe` = 1 to address k (0..29) loads `coefData` into tap k at that edge. The new value is used only by products of samples accepted after that edge. A sample accepted at the same edge, and partial sums already in the chain, keep the old value.
- R8: A write to address 30 or 31 changes no coefficient.
- R9: For the same inputs, the output differs from an exact-arithmetic FIR (same rounding and saturation) by at most 422 LSB.
- R10: With all coefficients at their reset value, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input sample offered |
| inReady | output | 1 | Filter can accept a sample |
| inSample | input | 16 | Signed Q1.15 input sample |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | 5 | Tap index for the write |
| coefData | input | 16 | Signed Q1.15 coefficient value |
| outValid | output | 1 | Output sample valid |
| outSample | output | 16 | Signed Q1.15 filtered output |

## Verification
The checker assumes three things about the inputs. `inValid` and `coefWe` are low while reset is held. Inputs change only away from the rising edge. Results are never back-pressured, so every accepted sample must come out two edges later. The bench drives all inputs on falling edges. It holds `inValid` low during reset and never stalls the output. It sweeps impulses, gapped random streams, mid-stream writes that include same-edge and out-of-range addresses, and full-scale patterns that force both saturation limits.

// File: rtl/tfir_pkg.sv
package tfir_pkg;

  // Strobes issued by the control to the datapath in each cycle
  typedef struct packed {
    logic accept;   // sample captured: shift the chain, register the sum
    logic drain;    // registered sum becomes the output sample
    logic coefWr;   // in-range coefficient write
  } ctrlStrobes_t;

endpackage

// File: rtl/tfir_truncmul.sv
// Signed truncated array multiplier in Baugh-Wooley form. Columns below
// W-1 are never formed; one carry equal to the OR of column W-2 is added
// at column W-1 in their place.
module tfir_truncmul #(
  parameter int W = 16
) (
  input  logic signed [W-1:0]   mulA,
  input  logic signed [W-1:0]   mulB,
  output logic signed [2*W-1:0] mulP
);
  localparam int PW   = 2 * W;
  localparam int KEEP = W - 1;   // lowest column that is built

  logic [PW-1:0] acc;
  logic          pp;
  logic          corr;

  always_comb begin
    acc  = '0;
    corr = 1'b0;
    pp   = 1'b0;
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        pp = mulA[i] & mulB[j];
        // Cross terms of one sign bit with a magnitude bit are inverted
        if ((i == W - 1) != (j == W - 1)) pp = ~pp;
        if (i + j >= KEEP) acc = acc + (PW'(pp) << (i + j));
        else if (i + j == KEEP - 1) corr = corr | pp;
      end
    end
    // Baugh-Wooley constants plus the data-dependent correction
    acc = acc + (PW'(1) << W) + (PW'(1) << (PW - 1)) + (PW'(corr) << KEEP);
  end

  assign mulP = signed'(acc);

endmodule

// File: rtl/tfir_ctrl.sv
module tfir_ctrl
  import tfir_pkg::*;
#(
  parameter int TAPS = 30,
  parameter int AWID = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic            coefWe,
  input  logic [AWID-1:0] coefAddr,
  output logic            inReady,
  output logic            outValid,
  output ctrlStrobes_t    strobes
);
  localparam logic [AWID-1:0] LASTTAP = AWID'(TAPS - 1);

  logic readyReg;
  logic stageValid;
  logic outValidReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      readyReg    <= 1'b0;
      stageValid  <= 1'b0;
      outValidReg <= 1'b0;
    end else begin
      readyReg    <= 1'b1;
      stageValid  <= inValid & readyReg;
      outValidReg <= stageValid;
    end
  end

  always_comb begin
    strobes.accept = inValid & readyReg;
    strobes.drain  = stageValid;
    strobes.coefWr = coefWe & (coefAddr <= LASTTAP);
  end

  assign inReady  = readyReg;
  assign outValid = outValidReg;

endmodule

// File: rtl/tfir_datapath.sv
module tfir_datapath
  import tfir_pkg::*;
#(
  parameter int TAPS = 30,
  parameter int W    = 16,
  parameter int AW   = 36,
  parameter int AWID = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strobes,
  input  logic signed [W-1:0] inSample,
  input  logic [AWID-1:0]     coefAddr,
  input  logic signed [W-1:0] coefData,
  output logic signed [W-1:0] outSample
);
  localparam int PW   = 2 * W;
  localparam int FRAC = W - 1;
  localparam logic signed [AW-1:0] HALF = AW'(1) << (FRAC - 1);
  localparam logic signed [AW-1:0] OMAX = AW'((2 ** (W - 1)) - 1);
  localparam logic signed [AW-1:0] OMIN = -OMAX - AW'(1);

  logic signed [W-1:0]  coefMem  [TAPS];
  logic signed [PW-1:0] prod     [TAPS];
  logic signed [AW-1:0] prodExt  [TAPS];
  logic signed [AW-1:0] chainReg [1:TAPS-1];
  logic signed [AW-1:0] sumReg;
  logic signed [AW-1:0] biased;
  logic signed [AW-1:0] scaled;
  logic signed [W-1:0]  satVal;

  // Coefficient bank
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) coefMem[k] <= '0;
    end else if (strobes.coefWr) begin
      coefMem[coefAddr] <= coefData;
    end
  end

  // One truncated multiplier per tap, all fed by the same sample
  for (genvar k = 0; k < TAPS; k++) begin : gTap
    tfir_truncmul #(.W(W)) uMul (
      .mulA(coefMem[k]),
      .mulB(inSample),
      .mulP(prod[k])
    );
    assign prodExt[k] = AW'(prod[k]);
  end

  // Transposed adder chain, advanced only on accepted samples
  for (genvar k = 1; k < TAPS; k++) begin : gChain
    if (k == TAPS - 1) begin : gTail
      always_ff @(posedge clk) begin
        if (rst) chainReg[k] <= '0;
        else if (strobes.accept) chainReg[k] <= prodExt[k];
      end
    end else begin : gMid
      always_ff @(posedge clk) begin
        if (rst) chainReg[k] <= '0;
        else if (strobes.accept) chainReg[k] <= chainReg[k+1] + prodExt[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sumReg <= '0;
    else if (strobes.accept) sumReg <= chainReg[1] + prodExt[0];
  end

  // Round half up to Q1.15 and clamp to the output range
  always_comb begin
    biased = sumReg + HALF;
    scaled = biased >>> FRAC;
    if (scaled > OMAX)      satVal = OMAX[W-1:0];
    else if (scaled < OMIN) satVal = OMIN[W-1:0];
    else                    satVal = scaled[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) outSample <= '0;
    else if (strobes.drain) outSample <= satVal;
  end

endmodule

// File: rtl/trunc_bcast_fir.sv
module trunc_bcast_fir
  import tfir_pkg::*;
#(
  parameter int TAPS = 30,
  parameter int W    = 16,
  parameter int AW   = 36,
  parameter int AWID = $clog2(TAPS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  output logic                inReady,
  input  logic signed [W-1:0] inSample,
  input  logic                coefWe,
  input  logic [AWID-1:0]     coefAddr,
  input  logic signed [W-1:0] coefData,
  output logic                outValid,
  output logic signed [W-1:0] outSample
);
  ctrlStrobes_t strobes;

  tfir_ctrl #(.TAPS(TAPS), .AWID(AWID)) uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .coefWe(coefWe),
    .coefAddr(coefAddr), .inReady(inReady), .outValid(outValid),
    .strobes(strobes)
  );

  tfir_datapath #(.TAPS(TAPS), .W(W), .AW(AW), .AWID(AWID)) uData (
    .clk(clk), .rst(rst), .strobes(strobes), .inSample(inSample),
    .coefAddr(coefAddr), .coefData(coefData), .outSample(outSample)
  );

endmodule

// File: rtl/tfir_checks.sv
module tfir_checks #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic         inReady,
  input logic         outValid,
  input logic [W-1:0] outSample
);
  logic seenRun;

  always_ff @(posedge clk) begin
    if (rst) seenRun <= 1'b0;
    else     seenRun <= 1'b1;
  end

  p_ready_after_reset_r2: assert property (@(posedge clk) disable iff (rst)
    seenRun |-> inReady);

  p_result_two_later_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |-> ##2 outValid);

  p_valid_has_source_r3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid && inReady, 2));

  p_output_held_r3: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outSample));

endmodule

bind trunc_bcast_fir tfir_checks #(.W(W)) uChecks (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outSample(outSample)
);

// File: tb/test_trunc_bcast_fir.sv
module test_trunc_bcast_fir;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS  = 30;
  // Per product the truncation error lies in (-14.0001, +1] output LSB, so
  // 30 taps stay under 421 LSB; one more covers the differing rounding.
  localparam int BOUND = 422;
  localparam int WDOG  = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic inReady;
  logic signed [15:0] inSample = '0;
  logic coefWe = 1'b0;
  logic [4:0] coefAddr = '0;
  logic signed [15:0] coefData = '0;
  logic outValid;
  logic signed [15:0] outSample;

  trunc_bcast_fir i_trunc_bcast_fir (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inSample(inSample), .coefWe(coefWe), .coefAddr(coefAddr),
    .coefData(coefData), .outValid(outValid), .outSample(outSample)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int posCount = 0;
  always @(posedge clk) posCount <= posCount + 1;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string curTag = "R1";

  int coefM [TAPS];
  int histX [TAPS];
  int histC [TAPS][TAPS];   // coefficient set in force when each sample arrived

  longint qT[$];
  longint qE[$];
  int     qDue[$];
  string  qTag[$];

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint truncMul(int a, int b);
    logic [15:0] ab = a[15:0];
    logic [15:0] bb = b[15:0];
    longint dropped = 0;
    bit c = 0;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        if (i + j <= 14 && ab[i] && bb[j]) begin
          dropped += longint'(1) << (i + j);
          if (i + j == 14) c = 1;
        end
    return longint'(a) * longint'(b) - dropped + (c ? 32768 : 0);
  endfunction

  function automatic longint roundSat(longint s);
    longint r = (s + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic acceptModel(int x);
    longint yt = 0;
    longint ye = 0;
    for (int k = TAPS - 1; k > 0; k--) begin
      histX[k] = histX[k-1];
      for (int t = 0; t < TAPS; t++) histC[k][t] = histC[k-1][t];
    end
    histX[0] = x;
    for (int t = 0; t < TAPS; t++) histC[0][t] = coefM[t];
    for (int k = 0; k < TAPS; k++) begin
      yt += truncMul(histC[k][k], histX[k]);
      ye += longint'(histC[k][k]) * longint'(histX[k]);
    end
    qT.push_back(roundSat(yt));
    qE.push_back(roundSat(ye));
    qDue.push_back(posCount + 2);
    qTag.push_back(curTag);
  endtask

  // Called just after a falling edge; returns at the next falling edge
  task automatic step(bit v, int x, bit we, int wa, int wd);
    inValid  = v;
    inSample = x[15:0];
    coefWe   = we;
    coefAddr = wa[4:0];
    coefData = wd[15:0];
    if (v && inReady) acceptModel(int'(signed'(x[15:0])));
    if (we && wa < TAPS) coefM[wa] = int'(signed'(wd[15:0]));
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Output monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (outValid) begin
        if (qDue.size() == 0 || qDue[0] != posCount) begin
          check(0, "R3", "outValid without accepted sample two edges back", 1, 0);
        end else begin
          check(longint'(outSample) == qT[0], qTag[0],
                "R4 R5 R6 output vs truncated model", longint'(outSample), qT[0]);
          check((longint'(outSample) - qE[0] <= BOUND) && (qE[0] - longint'(outSample) <= BOUND),
                "R9", "distance from exact FIR", longint'(outSample), qE[0]);
          void'(qT.pop_front()); void'(qE.pop_front());
          void'(qDue.pop_front()); void'(qTag.pop_front());
        end
      end else if (qDue.size() > 0 && qDue[0] == posCount) begin
        check(0, "R3", "missing outValid two edges after accept", 0, 1);
        void'(qT.pop_front()); void'(qE.pop_front());
        void'(qDue.pop_front()); void'(qTag.pop_front());
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R3 watchdog expired: actual=%0d expected=%0d", posCount, WDOG);
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < TAPS; k++) begin
      coefM[k] = 0;
      histX[k] = 0;
      for (int t = 0; t < TAPS; t++) histC[k][t] = 0;
    end

    // R1: state while reset is held
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
      check(outSample == 16'sd0, "R1", "outSample in reset", outSample, 0);
      check(inReady == 1'b0, "R1", "inReady in reset", inReady, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(inReady == 1'b1, "R2", "inReady after reset", inReady, 1);

    // R10: reset coefficients give zero output
    curTag = "R10";
    step(1, 16384, 0, 0, 0);
    step(1, -32768, 0, 0, 0);
    step(1, 32767, 0, 0, 0);
    idle(3);

    // Load a distinct coefficient per tap
    for (int k = 0; k < TAPS; k++) step(0, 0, 1, k, k * 1097 - 16000);

    // R4: impulses, with and without gaps between samples
    curTag = "R4";
    step(1, 32767, 0, 0, 0);
    idle(1);
    for (int i = 0; i < TAPS; i++) step(1, 0, 0, 0, 0);
    step(1, -32768, 0, 0, 0);
    for (int i = 0; i < TAPS; i++) step(i % 3 != 0, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) step(i % 2 == 0, i * 1500 - 30000, 0, 0, 0);
    idle(3);

    // R7: write in the same cycle as an accept, then sample after it
    curTag = "R7";
    step(1, 12345, 1, 0, -20000);
    step(1, 12345, 0, 0, 0);
    step(1, -9000, 1, 29, 31000);
    for (int i = 0; i < TAPS + 2; i++) step(1, 7000 - i * 400, (i % 5) == 2, i % TAPS, i * 900 - 14000);
    idle(3);

    // R8: out-of-range addresses leave all taps unchanged
    curTag = "R8";
    step(0, 0, 1, 30, 32767);
    step(0, 0, 1, 31, -32768);
    step(1, 32767, 1, 31, 12345);
    for (int i = 0; i < TAPS; i++) step(1, 0, i % 2 == 0, 30 + (i % 2), 5555);
    idle(3);

    // R5: gapped random streams with random writes
    curTag = "R5";
    for (int i = 0; i < 600; i++) begin
      int rx = int'($urandom % 65536) - 32768;
      int rw = int'($urandom % 65536) - 32768;
      step(($urandom % 4) != 0, rx, ($urandom % 16) == 0, int'($urandom % 32), rw);
    end
    idle(3);

    // R6: both saturation limits
    curTag = "R6";
    for (int k = 0; k < TAPS; k++) step(0, 0, 1, k, 32767);
    for (int i = 0; i < TAPS + 5; i++) step(1, 32767, 0, 0, 0);
    for (int i = 0; i < TAPS + 5; i++) step(1, -32768, 0, 0, 0);
    for (int k = 0; k < TAPS; k++) step(0, 0, 1, k, -32768);
    for (int i = 0; i < TAPS + 5; i++) step(1, -32768, 0, 0, 0);
    step(1, 100, 0, 0, 0);
    idle(4);
    check(qDue.size() == 0, "R3", "results still pending", qDue.size(), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule